// File: doc/BRIEF.md
# I2C Arbitration and Status Monitor

This block runs beside a byte-level I2C serial engine and keeps the status flags that a host reads. It watches the bus lines. It owns the master and transmitter role flags. When this device acts as master and the level seen on SDA at an SCL rising edge differs from the level the engine drives, the block records lost arbitration. It then drops at once to slave receiver, releases SDA until the current byte ends, and asks the clock generator to stop driving SCL from then on.

As a slave, the block checks the first byte after each start condition. It compares that byte with the configured 7-bit own address and with the all-zero general-call address. A free-data mode skips address recognition, and the first byte after a start marks the device as addressed. The block also keeps the SDA level seen at the latest SCL rising edge. Read straight after a byte-plus-acknowledge event, that level is the acknowledge bit. Each flag has its own clear event. Host accesses to the data register clear some flags, control-register writes clear others, and bus start or stop conditions clear the rest.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While `rst_n` is low, every output is 0. This means the block is an idle slave receiver with SDA not forced released.
- R2: A two-flop synchroniser feeds `scl_in` and `sda_in`. At each synchronised SCL rising edge, if `is_master` is 1 and the synchronised SDA differs from `sda_drive`, `arb_lost` becomes 1. The flag appears on the third clock edge after the SCL line rises. When `is_master` is 0, no mismatch sets `arb_lost`.
- R3: On the edge where `arb_lost` is set, `is_master` and `is_tx` both become 0.
- R4: A `data_acc` or `ctrl_wr` strobe clears `arb_lost` on the next edge. A new loss detected on that same edge takes priority and sets the flag.
- R5: `sda_release` is 1 from the loss until the next `byte_done`. At that `byte_done`, `sda_release` returns to 0 and `scl_hold` becomes 1. `scl_hold` stays 1 until `arb_lost` is cleared.
- R6: With `free_mode` = 0, suppose a `byte_done` is the first one after a `start_det` and `is_master` is 0. Then `addr_slave` is set if `rx_byte[7:1]` equals `own_addr` (bit 0, the R/W bit, is ignored) or if `rx_byte` is 8'h00. A later byte, or a byte received as master, never sets it.
- R7: With `free_mode` = 1, the first `byte_done` after a `start_det` sets `addr_slave` whatever its value, provided `is_master` is 0. `gen_call` is never set in this mode.
- R8: `data_acc` clears `addr_slave` on the next edge. A set on that same edge takes priority.
- R9: With `free_mode` = 0, a first byte of 8'h00 after a start, received while not master, sets `gen_call`. A `start_det` or `stop_det` clears it, and that clear takes priority over a set on the same edge.
- R10: `last_bit` holds the synchronised SDA level sampled at the most recent synchronised SCL rising edge. It changes on the same edge as the R2 check.
- R11: A `ctrl_wr` strobe loads `is_master` from `ctrl_master` and `is_tx` from `ctrl_tx` on the next edge, unless an arbitration loss happens on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_drive | input | 1 | SDA level the serial engine is driving |
| start_det | input | 1 | Start-condition pulse from the engine |
| stop_det | input | 1 | Stop-condition pulse from the engine |
| byte_done | input | 1 | Byte-complete strobe |
| rx_byte | input | 8 | Byte just received, valid with `byte_done` |
| own_addr | input | 7 | Configured own slave address |
| free_mode | input | 1 | 1 = free-data mode, 0 = address recognition |
| data_acc | input | 1 | Host read or write of the data register |
| ctrl_wr | input | 1 | Host write of the control register |
| ctrl_master | input | 1 | Master bit carried by the control write |
| ctrl_tx | input | 1 | Transmitter bit carried by the control write |
| arb_lost | output | 1 | Arbitration lost |
| is_master | output | 1 | Operating as master |
| is_tx | output | 1 | Operating as transmitter |
| addr_slave | output | 1 | Addressed as slave |
| gen_call | output | 1 | General call received |
| last_bit | output | 1 | Last SDA bit sampled at an SCL rising edge |
| sda_release | output | 1 | Force the internal SDA output high (released) |
| scl_hold | output | 1 | Stop driving the SCL output |

## Verification
All flags driven by strobes settle on the first clock edge after the strobe. Arbitration loss and `last_bit` come from the line inputs, so they lag by three edges: two synchroniser stages plus the edge-detect register. The bench's reference model keeps a short history queue of the sampled line inputs and takes its rising-edge decision from entries two and three edges old. This reproduces that latency without mirroring the flop chain. Both the model and the design are compared at every falling clock edge. The directed checks after each strobe are likewise sampled at the falling edge that follows the edge on which the result is due.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  typedef struct packed {
    logic master;
    logic tx;
  } role_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_mon_arb.sv
module i2c_mon_arb
  import i2c_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scl_rise,
  input  logic  sda_s,
  input  logic  sda_drive,
  input  logic  byte_done,
  input  logic  clr_req,
  input  logic  ctrl_wr,
  input  role_t ctrl_role,
  output role_t role,
  output logic  arb_lost,
  output logic  sda_release,
  output logic  scl_hold
);
  role_t role_n;
  logic  arb_n, rel_n, hold_n, loss;

  assign loss = scl_rise & role.master & (sda_s != sda_drive);

  always_comb begin
    role_n = role;
    arb_n  = arb_lost;
    rel_n  = sda_release;
    hold_n = scl_hold;
    if (ctrl_wr) role_n = ctrl_role;
    if (byte_done && sda_release) begin
      rel_n  = 1'b0;
      hold_n = 1'b1;
    end
    if (clr_req) begin
      arb_n  = 1'b0;
      rel_n  = 1'b0;
      hold_n = 1'b0;
    end
    if (loss) begin
      arb_n  = 1'b1;
      rel_n  = 1'b1;
      hold_n = 1'b0;
      role_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role        <= '0;
      arb_lost    <= 1'b0;
      sda_release <= 1'b0;
      scl_hold    <= 1'b0;
    end else begin
      role        <= role_n;
      arb_lost    <= arb_n;
      sda_release <= rel_n;
      scl_hold    <= hold_n;
    end
  end
endmodule

// File: rtl/i2c_mon_addr.sv
module i2c_mon_addr #(
  parameter int ADDR_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            byte_done,
  input  logic [ADDR_W:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic            free_mode,
  input  logic            is_master,
  input  logic            data_acc,
  output logic            addr_slave,
  output logic            gen_call
);
  logic first_pend, first_n, as_n, gc_n, hit, own_hit, zero_hit;

  assign hit      = byte_done & first_pend & ~is_master;
  assign own_hit  = (rx_byte[ADDR_W:1] == own_addr);
  assign zero_hit = (rx_byte == '0);

  always_comb begin
    first_n = first_pend;
    as_n    = addr_slave;
    gc_n    = gen_call;
    if (data_acc) as_n = 1'b0;
    if (hit) begin
      if (free_mode) begin
        as_n = 1'b1;
      end else begin
        if (own_hit || zero_hit) as_n = 1'b1;
        if (zero_hit)            gc_n = 1'b1;
      end
    end
    if (byte_done) first_n = 1'b0;
    if (start_det) begin
      first_n = 1'b1;
      gc_n    = 1'b0;
    end
    if (stop_det) begin
      first_n = 1'b0;
      gc_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pend <= 1'b0;
      addr_slave <= 1'b0;
      gen_call   <= 1'b0;
    end else begin
      first_pend <= first_n;
      addr_slave <= as_n;
      gen_call   <= gc_n;
    end
  end
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import i2c_mon_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              sda_drive,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              free_mode,
  input  logic              data_acc,
  input  logic              ctrl_wr,
  input  logic              ctrl_master,
  input  logic              ctrl_tx,
  output logic              arb_lost,
  output logic              is_master,
  output logic              is_tx,
  output logic              addr_slave,
  output logic              gen_call,
  output logic              last_bit,
  output logic              sda_release,
  output logic              scl_hold
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_s;
  logic  scl_s, sda_s, scl_prev, scl_rise, last_n;
  role_t role, ctrl_role;

  i2c_mon_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );

  assign scl_s    = line_s[1];
  assign sda_s    = line_s[0];
  assign scl_rise = scl_s & ~scl_prev;
  assign last_n   = scl_rise ? sda_s : last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      scl_prev <= scl_s;
      last_bit <= last_n;
    end
  end

  assign ctrl_role = '{master: ctrl_master, tx: ctrl_tx};

  i2c_mon_arb u_arb (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .sda_s(sda_s),
    .sda_drive(sda_drive), .byte_done(byte_done),
    .clr_req(data_acc | ctrl_wr), .ctrl_wr(ctrl_wr), .ctrl_role(ctrl_role),
    .role(role), .arb_lost(arb_lost), .sda_release(sda_release),
    .scl_hold(scl_hold)
  );

  assign is_master = role.master;
  assign is_tx     = role.tx;

  i2c_mon_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .rx_byte(rx_byte), .own_addr(own_addr),
    .free_mode(free_mode), .is_master(is_master), .data_acc(data_acc),
    .addr_slave(addr_slave), .gen_call(gen_call)
  );
endmodule

// File: rtl/i2c_mon_chk.sv
module i2c_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_rise,
  input logic sda_s,
  input logic last_bit,
  input logic arb_lost,
  input logic is_master,
  input logic is_tx,
  input logic sda_release,
  input logic scl_hold,
  input logic start_det,
  input logic stop_det,
  input logic gen_call,
  input logic addr_slave,
  input logic byte_done,
  input logic data_acc,
  input logic ctrl_wr
);
  // R10
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> (last_bit == $past(sda_s)));

  // R3
  lost_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!is_master && !is_tx));

  // R5
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> sda_release);

  // R5
  hold_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> arb_lost);

  // R4
  lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arb_lost) |-> $past(data_acc || ctrl_wr));

  // R9
  gc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !gen_call);

  // R6
  as_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_slave) |-> $past(byte_done));
endmodule

bind i2c_arb_monitor i2c_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .sda_s(sda_s),
  .last_bit(last_bit), .arb_lost(arb_lost), .is_master(is_master),
  .is_tx(is_tx), .sda_release(sda_release), .scl_hold(scl_hold),
  .start_det(start_det), .stop_det(stop_det), .gen_call(gen_call),
  .addr_slave(addr_slave), .byte_done(byte_done), .data_acc(data_acc),
  .ctrl_wr(ctrl_wr)
);

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_in, sda_in, sda_drive, start_det, stop_det, byte_done;
  logic [7:0] rx_byte;
  logic [6:0] own_addr;
  logic free_mode, data_acc, ctrl_wr, ctrl_master, ctrl_tx;
  logic arb_lost, is_master, is_tx, addr_slave, gen_call, last_bit;
  logic sda_release, scl_hold;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  i2c_arb_monitor uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_drive(sda_drive), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .rx_byte(rx_byte), .own_addr(own_addr),
    .free_mode(free_mode), .data_acc(data_acc), .ctrl_wr(ctrl_wr),
    .ctrl_master(ctrl_master), .ctrl_tx(ctrl_tx), .arb_lost(arb_lost),
    .is_master(is_master), .is_tx(is_tx), .addr_slave(addr_slave),
    .gen_call(gen_call), .last_bit(last_bit), .sda_release(sda_release),
    .scl_hold(scl_hold)
  );

  // Reference model: behavioural, with a history queue of line samples.
  bit m_arb, m_rel, m_hold, m_mst, m_tx, m_as, m_gc, m_first, m_lb;
  bit qscl[$];
  bit qsda[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_arb, m_rel, m_hold, m_mst, m_tx, m_as, m_gc, m_first, m_lb} = '0;
      qscl = '{0, 0, 0};
      qsda = '{0, 0, 0};
    end else begin
      bit rise, samp, loss, hit;
      rise = (qscl[1] == 1'b1) && (qscl[0] == 1'b0);
      samp = qsda[1];
      loss = rise && m_mst && (samp != sda_drive);
      hit  = byte_done && m_first && !m_mst;
      if (rise) m_lb = samp;
      if (ctrl_wr) begin m_mst = ctrl_master; m_tx = ctrl_tx; end
      if (byte_done && m_rel) begin m_rel = 0; m_hold = 1; end
      if (data_acc || ctrl_wr) begin m_arb = 0; m_rel = 0; m_hold = 0; end
      if (loss) begin m_arb = 1; m_rel = 1; m_hold = 0; m_mst = 0; m_tx = 0; end
      if (data_acc) m_as = 0;
      if (hit) begin
        if (free_mode) m_as = 1;
        else begin
          if (rx_byte[7:1] == own_addr || rx_byte == 8'h00) m_as = 1;
          if (rx_byte == 8'h00) m_gc = 1;
        end
      end
      if (byte_done) m_first = 0;
      if (start_det) begin m_first = 1; m_gc = 0; end
      if (stop_det)  begin m_first = 0; m_gc = 0; end
      qscl.push_back(scl_in); void'(qscl.pop_front());
      qsda.push_back(sda_in); void'(qsda.pop_front());
    end
  end

  task automatic check(string req, string name, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      check(cur_req, "arb_lost",    arb_lost,    m_arb);
      check(cur_req, "is_master",   is_master,   m_mst);
      check(cur_req, "is_tx",       is_tx,       m_tx);
      check(cur_req, "addr_slave",  addr_slave,  m_as);
      check(cur_req, "gen_call",    gen_call,    m_gc);
      check(cur_req, "last_bit",    last_bit,    m_lb);
      check(cur_req, "sda_release", sda_release, m_rel);
      check(cur_req, "scl_hold",    scl_hold,    m_hold);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=<50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit line, bit drv);
    @(negedge clk); sda_in = line; sda_drive = drv;
    wait_n(3); scl_in = 1'b1;
    wait_n(4); scl_in = 1'b0;
    wait_n(2);
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  task automatic do_byte(logic [7:0] b, bit with_acc);
    @(negedge clk); byte_done = 1'b1; rx_byte = b; data_acc = with_acc;
    @(negedge clk); byte_done = 1'b0; data_acc = 1'b0;
  endtask

  task automatic do_acc();
    @(negedge clk); data_acc = 1'b1;
    @(negedge clk); data_acc = 1'b0;
  endtask

  task automatic do_ctrl(bit m, bit t);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_master = m; ctrl_tx = t;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    {scl_in, sda_in, sda_drive, start_det, stop_det, byte_done} = '0;
    {free_mode, data_acc, ctrl_wr, ctrl_master, ctrl_tx} = '0;
    rx_byte = 8'h00;
    own_addr = 7'h3A;
    wait_n(3);
    // R1 reset state
    check("R1", "reset_flags",
          arb_lost | is_master | is_tx | addr_slave | gen_call |
          last_bit | sda_release | scl_hold, 1'b0);
    rst_n = 1'b1;
    wait_n(2);

    cur_req = "R10";
    send_bit(1'b1, 1'b1);
    check("R10", "last_bit", last_bit, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R10", "last_bit", last_bit, 1'b0);

    cur_req = "R2";
    send_bit(1'b0, 1'b1);
    check("R2", "arb_lost_not_master", arb_lost, 1'b0);

    cur_req = "R11";
    do_ctrl(1'b1, 1'b1);
    check("R11", "is_master", is_master, 1'b1);
    check("R11", "is_tx", is_tx, 1'b1);

    cur_req = "R2";
    send_bit(1'b1, 1'b1);
    check("R2", "arb_lost_match", arb_lost, 1'b0);
    send_bit(1'b0, 1'b1);
    check("R2", "arb_lost_mismatch", arb_lost, 1'b1);
    check("R3", "is_master", is_master, 1'b0);
    check("R3", "is_tx", is_tx, 1'b0);
    check("R5", "sda_release", sda_release, 1'b1);

    cur_req = "R5";
    do_byte(8'hFF, 1'b0);
    check("R5", "sda_release_end", sda_release, 1'b0);
    check("R5", "scl_hold", scl_hold, 1'b1);

    cur_req = "R4";
    do_acc();
    check("R4", "arb_lost_acc", arb_lost, 1'b0);
    check("R5", "scl_hold_clr", scl_hold, 1'b0);
    do_ctrl(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    check("R4", "arb_lost_again", arb_lost, 1'b1);
    do_ctrl(1'b0, 1'b0);
    check("R4", "arb_lost_ctrl", arb_lost, 1'b0);

    cur_req = "R6";
    do_start();
    do_byte({7'h3A, 1'b1}, 1'b0);
    check("R6", "own_match", addr_slave, 1'b1);
    check("R6", "no_gc", gen_call, 1'b0);
    cur_req = "R8";
    do_acc();
    check("R8", "as_clear", addr_slave, 1'b0);
    cur_req = "R6";
    do_byte({7'h3A, 1'b0}, 1'b0);
    check("R6", "not_first", addr_slave, 1'b0);
    do_start();
    do_byte({7'h3B, 1'b0}, 1'b0);
    check("R6", "mismatch", addr_slave, 1'b0);
    cur_req = "R8";
    do_start();
    do_byte({7'h3A, 1'b0}, 1'b1);
    check("R8", "set_wins", addr_slave, 1'b1);
    do_acc();
    cur_req = "R6";
    do_ctrl(1'b1, 1'b0);
    do_start();
    do_byte({7'h3A, 1'b0}, 1'b0);
    check("R6", "as_master", addr_slave, 1'b0);
    do_ctrl(1'b0, 1'b0);

    cur_req = "R9";
    do_start();
    do_byte(8'h00, 1'b0);
    check("R9", "gc_set", gen_call, 1'b1);
    check("R6", "gc_addr", addr_slave, 1'b1);
    do_stop();
    check("R9", "gc_stop", gen_call, 1'b0);
    do_acc();
    do_start();
    do_byte(8'h00, 1'b0);
    do_start();
    check("R9", "gc_start", gen_call, 1'b0);
    do_acc();

    cur_req = "R7";
    free_mode = 1'b1;
    do_start();
    do_byte(8'h55, 1'b0);
    check("R7", "free_first", addr_slave, 1'b1);
    do_acc();
    do_start();
    do_byte(8'h00, 1'b0);
    check("R7", "free_no_gc", gen_call, 1'b0);
    wait_n(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule